// File: doc/BRIEF.md
# PCI Target Command Responder

This block is the control state machine on the responding side of a 32-bit PCI-style bus target. At the start of each transaction it takes the bus command, sorts it into a read, a write or a code it will not answer, and then drives the three target handshake lines: device select, target ready and stop. Through these lines it can let the transfer run, hold it in wait states, ask the initiator to retry, disconnect it, or end it with a target abort.

An external address decoder reports a hit one clock after the address phase. The local side reports whether it can supply read data or accept write data, whether the current beat should be the last one, and whether the access has failed for good. A static configuration input sets how many wait clocks the first data phase may take before the block gives up and signals a retry. A short wait limit suits local data that is either ready at once or slow. A longer limit suits local data that usually arrives after a few clocks. A new transaction that begins on the clock right after the previous one ends is claimed with no idle clock between them. All bus outputs are active low and come straight from registers.

Top module: `pcit_responder`

## Requirements
- R1: While `rst` is high and on the first clock after it, `devsel_n`, `trdy_n` and `stop_n` are 1, `xfer_cls` is 0 and `data_beat` is 0.
- R2: The command codes 0000, 0001, 0100, 0101, 1000, 1001 and 1101 are never claimed. `devsel_n` stays 1 even when `addr_hit` is 1.
- R3: An address phase is a rising edge at which `frame_n` is 0 after having been 1 at the edge before. `cbe_n` is taken as the command at that edge (E0). `addr_hit` is sampled at edge E1. If the command is claimable and the hit is 1, `devsel_n` becomes 0 after E1. If the hit is 0, it stays 1.
- R4: Command codes 1100 and 1110 are reported on `cmd_norm` as 0110 and behave as that read. Code 1111 is reported as 0111 and behaves as that write.
- R5: Codes 0010, 0110 and 1010 (and their aliases) are reads: `xfer_cls` is 1 and readiness comes from `rd_ready`. Codes 0011, 0111 and 1011 (and their alias) are writes: `xfer_cls` is 2 and readiness comes from `wr_ready`.
- R6: Let L be `cfg_wait_limit`. On the first data phase, if the selected ready input is 1 at edge E1+1+k (k ≤ L, with no earlier ready), `trdy_n` becomes 0 after that edge. If it is still 0 at edge E1+1+L, a retry follows: `stop_n` is 0 with `trdy_n` 1.
- R7: A data beat completes at an edge where `irdy_n` and `trdy_n` are both 0. `data_beat` is 1 for the following clock. If `frame_n` is 1 at that edge, all three outputs return to 1 after it. `trdy_n` is 0 only while `devsel_n` is 0.
- R8: After a completed beat with `frame_n` still 0, if the selected ready input is 0, the block disconnects without data: `trdy_n` 1 and `stop_n` 0.
- R9: If `lcl_last` is 1 when a beat is made ready, `stop_n` and `trdy_n` go to 0 together (disconnect with data).
- R10: If `lcl_abort` is 1 when the next data phase is being decided, a target abort follows: `stop_n` 0, `devsel_n` 1, `trdy_n` 1.
- R11: Once `stop_n` is 0, it stays 0 until an edge that samples `frame_n` as 1. After that edge all three outputs are 1.
- R12: An address phase at the edge right after the edge that completed the last beat is accepted (fast back-to-back), and `devsel_n` becomes 0 one edge later.
- R13: While `trdy_n` is 0 and `irdy_n` is 1, `trdy_n` stays 0 and no beat is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command on the address phase |
| addr_hit | input | 1 | Decoder hit, valid the clock after the address phase |
| rd_ready | input | 1 | Local side can supply read data |
| wr_ready | input | 1 | Local side can accept write data |
| lcl_last | input | 1 | Make the next ready beat the final one |
| lcl_abort | input | 1 | Local access failed; end with target abort |
| cfg_wait_limit | input | CNT_W | First-phase wait clocks allowed before retry |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop, active low |
| xfer_cls | output | 2 | Class of the claimed transaction: 0 none, 1 read, 2 write |
| cmd_norm | output | 4 | Claimed command after aliasing |
| data_beat | output | 1 | One clock after each completed beat |

## Verification
The assertions assume that the initiator follows bus protocol. It keeps `frame_n` low through the address phase and the decode clock, raises `frame_n` no later than the final beat, and starts a new frame only after the previous one has ended or been stopped. The ignored-command property in particular relies on address phases appearing only when the block is idle. Every stimulus sequence in the bench is written as a well-formed initiator would issue it. Each sequence drives the address phase, then the decode clock, then one or more data phases, and it releases `frame_n` once a stop is seen. It never starts a frame in the middle of another.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_READ  = 2'd1,
    CLS_WRITE = 2'd2
  } xfer_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_FIRST,
    ST_DATA,
    ST_STOP
  } tgt_state_e;

  typedef struct packed {
    xfer_cls_e  cls;
    logic [3:0] norm;
  } cmd_info_t;

endpackage

// File: rtl/pcit_cmd_decode.sv
module pcit_cmd_decode
  import pcit_pkg::*;
(
  input  logic [3:0] cmd,
  output cmd_info_t  info
);

  always_comb begin
    info.cls  = CLS_NONE;
    info.norm = cmd;
    case (cmd)
      4'b0010, 4'b0110, 4'b1010: info.cls = CLS_READ;
      4'b0011, 4'b0111, 4'b1011: info.cls = CLS_WRITE;
      4'b1100, 4'b1110: begin
        info.cls  = CLS_READ;
        info.norm = 4'b0110;
      end
      4'b1111: begin
        info.cls  = CLS_WRITE;
        info.norm = 4'b0111;
      end
      default: begin
        info.cls  = CLS_NONE;
        info.norm = 4'b0000;
      end
    endcase
  end

endmodule

// File: rtl/pcit_addr_detect.sv
module pcit_addr_detect (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  output logic addr_start
);

  logic frame_q;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end

  assign addr_start = !frame_n && frame_q;

endmodule

// File: rtl/pcit_wait_timer.sv
module pcit_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                  cnt <= '0;
    else if (tick && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

endmodule

// File: rtl/pcit_responder.sv
module pcit_responder
  import pcit_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [CMD_W-1:0] cbe_n,
  input  logic             addr_hit,
  input  logic             rd_ready,
  input  logic             wr_ready,
  input  logic             lcl_last,
  input  logic             lcl_abort,
  input  logic [CNT_W-1:0] cfg_wait_limit,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic [1:0]       xfer_cls,
  output logic [CMD_W-1:0] cmd_norm,
  output logic             data_beat
);

  tgt_state_e       state;
  logic [CMD_W-1:0] cmd_q;
  cmd_info_t        info;
  logic             addr_start;
  logic             claim;
  logic             lcl_ready;
  logic             wt_expired;
  logic             wt_clear;
  logic             wt_tick;
  logic             beat_done;

  pcit_addr_detect u_addr (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .addr_start (addr_start)
  );

  pcit_cmd_decode u_dec (
    .cmd  (cmd_q),
    .info (info)
  );

  assign claim     = addr_hit && (info.cls != CLS_NONE);
  assign lcl_ready = (xfer_cls == CLS_WRITE) ? wr_ready : rd_ready;
  assign wt_clear  = (state != ST_FIRST);
  assign wt_tick   = (state == ST_FIRST) && !lcl_ready;
  assign beat_done = (state == ST_DATA) && !trdy_n && !irdy_n;

  pcit_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .clear   (wt_clear),
    .tick    (wt_tick),
    .limit   (cfg_wait_limit),
    .expired (wt_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      devsel_n  <= 1'b1;
      trdy_n    <= 1'b1;
      stop_n    <= 1'b1;
      xfer_cls  <= CLS_NONE;
      cmd_norm  <= '0;
      data_beat <= 1'b0;
    end else begin
      data_beat <= beat_done;
      case (state)
        ST_IDLE: begin
          if (addr_start) begin
            cmd_q <= cbe_n;
            state <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (claim) begin
            devsel_n <= 1'b0;
            xfer_cls <= info.cls;
            cmd_norm <= info.norm;
            state    <= ST_FIRST;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_FIRST: begin
          if (lcl_abort) begin
            stop_n   <= 1'b0;
            devsel_n <= 1'b1;
            state    <= ST_STOP;
          end else if (lcl_ready) begin
            trdy_n <= 1'b0;
            stop_n <= !lcl_last;
            state  <= ST_DATA;
          end else if (wt_expired) begin
            stop_n <= 1'b0;
            state  <= ST_STOP;
          end
        end
        ST_DATA: begin
          if (beat_done) begin
            if (frame_n) begin
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              stop_n   <= 1'b1;
              xfer_cls <= CLS_NONE;
              state    <= ST_IDLE;
            end else if (!stop_n) begin
              trdy_n <= 1'b1;
              state  <= ST_STOP;
            end else if (lcl_abort) begin
              trdy_n   <= 1'b1;
              stop_n   <= 1'b0;
              devsel_n <= 1'b1;
              state    <= ST_STOP;
            end else if (lcl_ready) begin
              stop_n <= !lcl_last;
            end else begin
              trdy_n <= 1'b1;
              stop_n <= 1'b0;
              state  <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (frame_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            xfer_cls <= CLS_NONE;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcit_checker.sv
module pcit_checker (
  input logic       clk,
  input logic       rst,
  input logic       frame_n,
  input logic       irdy_n,
  input logic [3:0] cbe_n,
  input logic       addr_phase,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n
);

  logic ign_cmd;
  always_comb begin
    case (cbe_n)
      4'b0000, 4'b0001, 4'b0100, 4'b0101,
      4'b1000, 4'b1001, 4'b1101: ign_cmd = 1'b1;
      default:                   ign_cmd = 1'b0;
    endcase
  end

  p_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && ign_cmd) |=> devsel_n ##1 devsel_n);

  p_trdy_needs_devsel_r7: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  p_abort_shape_r10: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && devsel_n) |-> trdy_n);

  p_stop_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && !frame_n) |=> !stop_n);

  p_trdy_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> !trdy_n);

endmodule

bind pcit_responder pcit_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .cbe_n      (cbe_n),
  .addr_phase (addr_start),
  .devsel_n   (devsel_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n)
);

// File: tb/sim_pcit_responder.sv
module sim_pcit_responder;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_n, irdy_n, addr_hit, rd_ready, wr_ready, lcl_last, lcl_abort;
  logic [3:0] cbe_n;
  logic [3:0] cfg_wait_limit;
  logic       devsel_n, trdy_n, stop_n, data_beat;
  logic [1:0] xfer_cls;
  logic [3:0] cmd_norm;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  pcit_responder u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .addr_hit(addr_hit), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .lcl_last(lcl_last), .lcl_abort(lcl_abort), .cfg_wait_limit(cfg_wait_limit),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .xfer_cls(xfer_cls), .cmd_norm(cmd_norm), .data_beat(data_beat)
  );

  // {cmd[3:0], hit, claim, cls[1:0], norm[3:0]}
  localparam logic [11:0] VEC [0:17] = '{
    12'b0000_1_0_00_0000, 12'b0001_1_0_00_0000, 12'b0010_1_1_01_0010,
    12'b0011_1_1_10_0011, 12'b0100_1_0_00_0000, 12'b0101_1_0_00_0000,
    12'b0110_1_1_01_0110, 12'b0111_1_1_10_0111, 12'b1000_1_0_00_0000,
    12'b1001_1_0_00_0000, 12'b1010_1_1_01_1010, 12'b1011_1_1_10_1011,
    12'b1100_1_1_01_0110, 12'b1101_1_0_00_0000, 12'b1110_1_1_01_0110,
    12'b1111_1_1_10_0111, 12'b0110_0_0_00_0000, 12'b0111_0_0_00_0000
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; addr_hit = 1'b0; rd_ready = 1'b0;
    wr_ready = 1'b0; lcl_last = 1'b0; lcl_abort = 1'b0; cbe_n = 4'b1111;
    step(); step();
  endtask

  // Address phase then decode clock; leaves caller just after E1.
  task automatic start_txn(input logic [3:0] cmd, input logic hit, input logic last_frame,
                           input logic irdy_v);
    frame_n = 1'b0; cbe_n = cmd;
    step();                                 // E0
    addr_hit = hit; frame_n = last_frame; irdy_n = irdy_v; cbe_n = 4'b0000;
    step();                                 // E1
    addr_hit = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_wait_limit = 4'd0;
    frame_n = 1'b1; irdy_n = 1'b1; addr_hit = 1'b0; rd_ready = 1'b0;
    wr_ready = 1'b0; lcl_last = 1'b0; lcl_abort = 1'b0; cbe_n = 4'b1111;
    step(); step(); step();
    chk("R1 devsel in reset", {7'd0, devsel_n}, 8'd1);
    chk("R1 trdy in reset",   {7'd0, trdy_n},   8'd1);
    chk("R1 stop in reset",   {7'd0, stop_n},   8'd1);
    chk("R1 class in reset",  {6'd0, xfer_cls}, 8'd0);
    rst = 1'b0;
    step();
    chk("R1 beat after reset", {7'd0, data_beat}, 8'd0);
    chk("R1 devsel after reset", {7'd0, devsel_n}, 8'd1);

    // Vector table: single-beat transactions over every command code (R2 R3 R4 R5 R7)
    for (int i = 0; i < 18; i++) begin
      logic [3:0] vc; logic vh, vcl; logic [1:0] vk; logic [3:0] vn;
      {vc, vh, vcl, vk, vn} = VEC[i];
      rd_ready = 1'b1; wr_ready = 1'b1;
      frame_n = 1'b0; cbe_n = vc;
      step();                               // E0
      chk("R3 no devsel at address phase", {7'd0, devsel_n}, 8'd1);
      addr_hit = vh; frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000;
      step();                               // E1
      addr_hit = 1'b0;
      chk($sformatf("R2 R3 claim cmd=%b hit=%b", vc, vh), {7'd0, devsel_n}, {7'd0, !vcl});
      chk($sformatf("R5 class cmd=%b", vc), {6'd0, xfer_cls}, {6'd0, vk});
      if (vcl) chk($sformatf("R4 alias cmd=%b", vc), {4'd0, cmd_norm}, {4'd0, vn});
      step();                               // E2
      chk($sformatf("R5 trdy cmd=%b", vc), {7'd0, trdy_n}, {7'd0, !vcl});
      step();                               // E3
      chk($sformatf("R7 beat cmd=%b", vc), {7'd0, data_beat}, {7'd0, vcl});
      chk("R7 release after last", {5'd0, devsel_n, trdy_n, stop_n}, 8'd7);
      bus_idle();
    end

    // R5: a read ignores wr_ready; a write ignores rd_ready
    rd_ready = 1'b0; wr_ready = 1'b1; cfg_wait_limit = 4'd0;
    start_txn(4'b0110, 1'b1, 1'b1, 1'b0);
    step();
    chk("R5 read waits on rd_ready only", {6'd0, trdy_n, stop_n}, 8'b10);
    bus_idle();
    rd_ready = 1'b1; wr_ready = 1'b0;
    start_txn(4'b0111, 1'b1, 1'b1, 1'b0);
    step();
    chk("R5 write waits on wr_ready only", {6'd0, trdy_n, stop_n}, 8'b10);
    bus_idle();

    // R6 + R11: retry after two wait clocks, stop held while frame low
    cfg_wait_limit = 4'd2;
    start_txn(4'b0110, 1'b1, 1'b0, 1'b0);
    step();                                 // E2
    chk("R6 waiting E2", {5'd0, devsel_n, trdy_n, stop_n}, 8'b011);
    step();                                 // E3
    chk("R6 waiting E3", {5'd0, devsel_n, trdy_n, stop_n}, 8'b011);
    step();                                 // E4
    chk("R6 retry at limit", {5'd0, devsel_n, trdy_n, stop_n}, 8'b010);
    step();                                 // E5, frame still low
    chk("R11 stop held", {7'd0, stop_n}, 8'd0);
    frame_n = 1'b1;
    step();
    chk("R11 release after frame high", {5'd0, devsel_n, trdy_n, stop_n}, 8'b111);
    bus_idle();

    // R6: ready arrives inside the window
    cfg_wait_limit = 4'd2;
    start_txn(4'b0110, 1'b1, 1'b1, 1'b0);
    step();                                 // E2 not ready
    rd_ready = 1'b1;
    step();                                 // E3 ready
    chk("R6 ready inside window", {6'd0, trdy_n, stop_n}, 8'b01);
    step();
    chk("R6 beat after window ready", {7'd0, data_beat}, 8'd1);
    bus_idle();

    // R6: zero limit means immediate retry
    cfg_wait_limit = 4'd0;
    start_txn(4'b0111, 1'b1, 1'b1, 1'b0);
    step();
    chk("R6 immediate retry", {5'd0, devsel_n, trdy_n, stop_n}, 8'b010);
    bus_idle();

    // R8: disconnect without data on second phase
    wr_ready = 1'b1;
    start_txn(4'b0111, 1'b1, 1'b0, 1'b0);
    step();                                 // E2 trdy low
    wr_ready = 1'b0;
    step();                                 // E3 beat, not ready
    chk("R8 disconnect no data", {5'd0, devsel_n, trdy_n, stop_n}, 8'b010);
    chk("R8 first beat counted", {7'd0, data_beat}, 8'd1);
    frame_n = 1'b1;
    step();
    chk("R8 release", {5'd0, devsel_n, trdy_n, stop_n}, 8'b111);
    bus_idle();

    // R9: disconnect with data
    rd_ready = 1'b1; lcl_last = 1'b1;
    start_txn(4'b0110, 1'b1, 1'b0, 1'b0);
    step();                                 // E2
    chk("R9 stop with trdy", {5'd0, devsel_n, trdy_n, stop_n}, 8'b000);
    frame_n = 1'b1;
    step();
    chk("R9 beat then release", {4'd0, data_beat, devsel_n, trdy_n, stop_n}, 8'b1111);
    bus_idle();

    // R10: target abort on first phase
    wr_ready = 1'b1; lcl_abort = 1'b1;
    start_txn(4'b0111, 1'b1, 1'b0, 1'b0);
    step();
    chk("R10 abort shape", {5'd0, devsel_n, trdy_n, stop_n}, 8'b110);
    frame_n = 1'b1;
    step();
    chk("R10 release", {5'd0, devsel_n, trdy_n, stop_n}, 8'b111);
    bus_idle();

    // R10: target abort after a beat
    rd_ready = 1'b1;
    start_txn(4'b0110, 1'b1, 1'b0, 1'b0);
    step();                                 // E2 trdy low
    lcl_abort = 1'b1;
    step();                                 // E3 beat, abort decided
    chk("R10 abort mid burst", {5'd0, devsel_n, trdy_n, stop_n}, 8'b110);
    bus_idle();

    // R13: initiator wait holds trdy
    rd_ready = 1'b1;
    start_txn(4'b0110, 1'b1, 1'b0, 1'b1);
    step();                                 // E2 trdy low
    step();                                 // E3 irdy high
    chk("R13 trdy held", {6'd0, trdy_n, data_beat}, 8'b00);
    irdy_n = 1'b0; frame_n = 1'b1;
    step();                                 // E4 beat
    chk("R13 beat after irdy", {4'd0, data_beat, devsel_n, trdy_n, stop_n}, 8'b1111);
    bus_idle();

    // R12: fast back-to-back
    wr_ready = 1'b1; rd_ready = 1'b1;
    start_txn(4'b0111, 1'b1, 1'b1, 1'b0);
    step();                                 // E2 trdy low
    step();                                 // E3 beat, last
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'b0110;
    step();                                 // E4 address phase
    chk("R12 no idle needed", {7'd0, devsel_n}, 8'd1);
    addr_hit = 1'b1; frame_n = 1'b1; irdy_n = 1'b0;
    step();                                 // E5
    addr_hit = 1'b0;
    chk("R12 back-to-back claimed", {5'd0, devsel_n, xfer_cls}, 8'b001);
    bus_idle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule